// File: doc/BRIEF.md
# Per-Core Banked Timer Register Window

This block wraps one timer and one watchdog per core, for one to four cores, behind a single 32-bit register space. Every access carries the identifier of the core that issued it. Two shared windows are core-relative: window 0 reaches the caller's own timer and window 1 reaches the caller's own watchdog. Further windows give direct access to any core's instance: window 2+2k reaches core k's timer and window 3+2k reaches core k's watchdog. Each window is 0x20 bytes, so the window index is the address above bit 5 and the register is chosen by bits 4:2.

Instances are numbered so that core k's timer is instance 2k and its watchdog is instance 2k+1. Each instance drives one interrupt line at that index of the `irq` vector. Timer and watchdog instances are identical down-counters with a prescaler, a reload value and a sticky expiry flag.

Every request gets exactly one response on the cycle after it. The response flags illegal accesses instead of forwarding them. The request side has no back-pressure: a request is taken on every cycle that `req_valid` is high, and the requester must accept every response.

Top module: `bnk_tmr_win`

## Requirements
- R1: A request to window 0 from core c, where c < NCORE, reaches instance 2c (core c's timer).
- R2: A request to window 1 from core c, where c < NCORE, reaches instance 2c+1 (core c's watchdog).
- R3: A request to window 2+i, where i < 2·NCORE, reaches instance i whatever the core identifier is.
- R4: `irq[i]` is the interrupt of instance i. The order is core 0 timer, core 0 watchdog, core 1 timer, and so on.
- R5: Only aligned word accesses are legal: `req_size` must be 2 and `req_addr[1:0]` must be 0. Any other access returns zero with `rsp_err` set, and its write changes nothing.
- R6: A request to window 0 or 1 with a core identifier ≥ NCORE returns zero with `rsp_err` set, and its write changes nothing.
- R7: A request to a window ≥ 2+2·NCORE returns zero with `rsp_err` set.
- R8: Each request produces `rsp_valid` high for exactly one cycle, on the cycle after the request. No response appears without a request. Write responses carry zero data.
- R9: After reset, every instance reads zero in all of its registers and every `irq` line is low.
- R10: Register offsets within a window are as follows.
  - 0x0: reload value. A write to it also sets the count.
  - 0x4: current count.
  - 0x8: control. Bit 0 enables counting, bit 1 enables auto-reload, bits 15:8 set the prescale, and the other bits read zero.
  - 0xC: expiry status in bit 0, cleared by writing 1.
  - 0x10 to 0x1C: read zero without error.
- R11: While enabled, the count falls by one every prescale+1 cycles. When it falls from 1, the status bit and the irq line are set. The count then reloads from the reload value if auto-reload is set; otherwise it goes to 0 and stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe; one request per high cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte address: window index above bit 5, register in bits 4:2 |
| req_size | input | 2 | Log2 of access bytes; only 2 is legal |
| req_core | input | CORE_W | Identifier of the requesting core |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data; zero for writes and errors |
| rsp_err | output | 1 | Request was illegal and had no effect |
| irq | output | 2·NCORE | Interrupt of each instance, in instance order |

## Verification
The assertions take for granted that `req_core` and the other request fields are stable and known while `req_valid` is high. They also assume no response is ever refused, because the block has no way to hold one back. The bench drives every request field at the falling edge for exactly one cycle and returns `req_valid` to zero between tasks. It also keeps core identifiers within the port width, so every out-of-range identifier it uses is a legal port value that is simply above NCORE−1. When a timer is running, the bench does not assume when a count read is sampled. It reads counts only with the counter stopped, and it watches running behaviour only through the irq lines and the status register.

// File: rtl/bnk_tmr_pkg.sv
package bnk_tmr_pkg;
  localparam int WIN_SHIFT = 5;             // 0x20 bytes per window
  localparam int REG_SEL_W = 3;             // word index within window
  localparam logic [1:0] SIZE_WORD = 2'd2;  // log2(4 bytes)
  localparam logic [31:0] CTRL_MASK = 32'h0000_FF03;

  typedef enum logic [REG_SEL_W-1:0] {
    REG_RELOAD = 3'd0,
    REG_COUNT  = 3'd1,
    REG_CTRL   = 3'd2,
    REG_STAT   = 3'd3
  } reg_sel_e;
endpackage

// File: rtl/bnk_tmr_decode.sv
module bnk_tmr_decode #(
  parameter int NCORE  = 2,
  parameter int AW     = 9,
  parameter int CORE_W = 2,
  localparam int NINST = 2 * NCORE,
  localparam int IW    = $clog2(NINST),
  localparam int WW    = AW - bnk_tmr_pkg::WIN_SHIFT
) (
  input  logic [AW-1:0]     addr,
  input  logic [1:0]        size,
  input  logic [CORE_W-1:0] core,
  output logic [IW-1:0]     tgt,
  output logic [bnk_tmr_pkg::REG_SEL_W-1:0] reg_sel,
  output logic              err
);
  import bnk_tmr_pkg::*;

  logic [WW-1:0] win;
  assign win     = addr[AW-1:WIN_SHIFT];
  assign reg_sel = addr[WIN_SHIFT-1:2];

  always_comb begin
    int w;
    int c;
    int t;
    w   = int'(win);
    c   = int'(core);
    t   = 0;
    err = 1'b0;
    if (size != SIZE_WORD || addr[1:0] != 2'b00) begin
      err = 1'b1;
    end else if (w < 2) begin
      // core-relative alias: timer at 2c, watchdog at 2c+1
      if (c >= NCORE) err = 1'b1;
      else            t   = 2 * c + w;
    end else if (w - 2 < NINST) begin
      t = w - 2;
    end else begin
      err = 1'b1;
    end
    tgt = IW'(t);
  end
endmodule

// File: rtl/bnk_tmr_unit.sv
module bnk_tmr_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [bnk_tmr_pkg::REG_SEL_W-1:0] reg_sel,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  import bnk_tmr_pkg::*;

  logic [31:0] reload_q, count_q, ctrl_q;
  logic [7:0]  pre_q;
  logic        stat_q;
  logic        en, auto_rl, tick;
  logic [7:0]  presc;

  assign en      = ctrl_q[0];
  assign auto_rl = ctrl_q[1];
  assign presc   = ctrl_q[15:8];
  assign tick    = en && (count_q != 32'd0) && (pre_q == presc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      count_q  <= '0;
      ctrl_q   <= '0;
      pre_q    <= '0;
      stat_q   <= 1'b0;
    end else if (wr_en) begin
      case (reg_sel)
        REG_RELOAD: begin
          reload_q <= wdata;
          count_q  <= wdata;
          pre_q    <= '0;
        end
        REG_COUNT: begin
          count_q <= wdata;
          pre_q   <= '0;
        end
        REG_CTRL: begin
          ctrl_q <= wdata & CTRL_MASK;
          pre_q  <= '0;
          if (!en && wdata[0] && wdata[1] && count_q == 32'd0)
            count_q <= reload_q;
        end
        REG_STAT: if (wdata[0]) stat_q <= 1'b0;
        default: ;
      endcase
    end else if (en && count_q != 32'd0) begin
      if (tick) begin
        pre_q <= '0;
        if (count_q == 32'd1) begin
          stat_q  <= 1'b1;
          count_q <= auto_rl ? reload_q : 32'd0;
        end else begin
          count_q <= count_q - 32'd1;
        end
      end else begin
        pre_q <= pre_q + 8'd1;
      end
    end
  end

  always_comb begin
    case (reg_sel)
      REG_RELOAD: rdata = reload_q;
      REG_COUNT:  rdata = count_q;
      REG_CTRL:   rdata = ctrl_q;
      REG_STAT:   rdata = {31'd0, stat_q};
      default:    rdata = 32'd0;
    endcase
  end

  assign irq = stat_q;

  // R10
  irq_clear_only_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(wr_en && reg_sel == REG_STAT && wdata[0]));

  // R11
  irq_rise_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(en && !wr_en));
endmodule

// File: rtl/bnk_tmr_win.sv
module bnk_tmr_win #(
  parameter int NCORE  = 2,
  parameter int AW     = 9,
  parameter int CORE_W = 2,
  localparam int NINST = 2 * NCORE,
  localparam int IW    = $clog2(NINST)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [1:0]        req_size,
  input  logic [CORE_W-1:0] req_core,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic [NINST-1:0]  irq
);
  import bnk_tmr_pkg::*;

  logic [IW-1:0]        tgt;
  logic [REG_SEL_W-1:0] reg_sel;
  logic                 dec_err;
  logic [NINST-1:0]     sel_vec;
  logic [31:0]          rd_arr [NINST];
  logic [31:0]          rd_mux;

  bnk_tmr_decode #(.NCORE(NCORE), .AW(AW), .CORE_W(CORE_W)) dec_i (
    .addr    (req_addr),
    .size    (req_size),
    .core    (req_core),
    .tgt     (tgt),
    .reg_sel (reg_sel),
    .err     (dec_err)
  );

  for (genvar i = 0; i < NINST; i++) begin : g_inst
    assign sel_vec[i] = req_valid && !dec_err && (tgt == IW'(i));
    bnk_tmr_unit unit_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (sel_vec[i] && req_write),
      .reg_sel (reg_sel),
      .wdata   (req_wdata),
      .rdata   (rd_arr[i]),
      .irq     (irq[i])
    );
  end

  always_comb begin
    rd_mux = 32'd0;
    for (int i = 0; i < NINST; i++)
      if (sel_vec[i]) rd_mux = rd_arr[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && dec_err;
      rsp_rdata <= (req_valid && !req_write) ? rd_mux : 32'd0;
    end
  end

  // R1
  at_most_one_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_vec));

  // R5
  bad_size_flagged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_size != SIZE_WORD |=> rsp_valid && rsp_err);

  // R6
  err_blocks_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && dec_err |-> sel_vec == '0);

  // R8
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R8
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R7
  err_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid && rsp_rdata == 32'd0);
endmodule

// File: tb/bnk_tmr_win_tb_top.sv
module bnk_tmr_win_tb_top;
  localparam int NCORE = 2;
  localparam int AW    = 9;
  localparam int NI    = 2 * NCORE;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 2'd2;
  logic [1:0]    req_core = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid, rsp_err;
  logic [31:0]   rsp_rdata;
  logic [NI-1:0] irq;

  int nchk = 0;
  int nerr = 0;

  typedef struct { logic [31:0] data; logic err; string tag; } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  bnk_tmr_win #(.NCORE(NCORE), .AW(AW), .CORE_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_core(req_core),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err), .irq(irq));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] wa(input int win, input int off);
    return AW'(win * 32 + off);
  endfunction

  // driver: one request, expectation pushed to scoreboard
  task automatic req(input bit wr, input logic [AW-1:0] a, input logic [1:0] sz,
                     input logic [1:0] core, input logic [31:0] wd,
                     input logic [31:0] exp_d, input bit exp_e, input string tag);
    exp_t e;
    e.data = wr ? 32'd0 : exp_d;
    e.err  = exp_e;
    e.tag  = tag;
    sb_q.push_back(e);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz;
    req_core = core; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R8 unexpected response", {31'd0, rsp_valid}, 32'd0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk(rsp_rdata == e.data, {e.tag, " data"}, rsp_rdata, e.data);
        chk(rsp_err == e.err, {e.tag, " err"}, {31'd0, rsp_err}, {31'd0, e.err});
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog expired", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(irq == '0, "R9 irq after reset", 32'(irq), 32'd0);
    for (int w = 2; w < 2 + NI; w++)
      for (int o = 0; o < 16; o += 4)
        req(0, wa(w, o), 2'd2, 2'd0, 0, 32'd0, 0, "R9 reset read");

    // R1 / R10: core 0 timer via alias, read back via absolute window 2
    req(1, wa(0, 0), 2'd2, 2'd0, 32'd5, 0, 0, "R1 write reload");
    req(0, wa(2, 0), 2'd2, 2'd3, 0, 32'd5, 0, "R1 R3 reload readback");
    req(0, wa(2, 4), 2'd2, 2'd1, 0, 32'd5, 0, "R10 reload sets count");
    req(0, wa(2, 16), 2'd2, 2'd0, 0, 32'd0, 0, "R10 unused offset");
    // R2: core 1 watchdog via alias, instance 3 = window 5
    req(1, wa(1, 0), 2'd2, 2'd1, 32'd2, 0, 0, "R2 write wdog reload");
    req(0, wa(5, 0), 2'd2, 2'd0, 0, 32'd2, 0, "R2 R3 wdog readback");
    req(0, wa(3, 0), 2'd2, 2'd0, 0, 32'd0, 0, "R2 core0 wdog untouched");
    req(0, wa(1, 0), 2'd2, 2'd1, 0, 32'd2, 0, "R2 alias read");
    // R3: absolute write to core 1 timer (window 4) ignores core id
    req(1, wa(4, 8), 2'd2, 2'd3, 32'hFFFF_FF00, 0, 0, "R3 write ctrl");
    req(0, wa(0, 8), 2'd2, 2'd1, 0, 32'h0000_FF00, 0, "R3 R10 ctrl mask");
    req(1, wa(4, 8), 2'd2, 2'd0, 32'd0, 0, 0, "R3 ctrl restore");

    // R5: illegal size and misalignment, write ignored
    req(1, wa(2, 0), 2'd1, 2'd0, 32'd9, 0, 1, "R5 half write");
    req(1, wa(2, 0) | AW'(1), 2'd2, 2'd0, 32'd9, 0, 1, "R5 misaligned write");
    req(0, wa(2, 0), 2'd0, 2'd0, 0, 32'd0, 1, "R5 byte read");
    req(0, wa(2, 0), 2'd2, 2'd0, 0, 32'd5, 0, "R5 reload unchanged");
    // R6: alias with core beyond NCORE
    req(0, wa(0, 0), 2'd2, 2'd2, 0, 32'd0, 1, "R6 bad core read");
    req(1, wa(1, 0), 2'd2, 2'd3, 32'd7, 0, 1, "R6 bad core write");
    req(0, wa(5, 0), 2'd2, 2'd0, 0, 32'd2, 0, "R6 wdog unchanged");
    // R7: windows past the last instance
    req(0, wa(6, 0), 2'd2, 2'd0, 0, 32'd0, 1, "R7 window 6");
    req(1, wa(15, 0), 2'd2, 2'd0, 32'd1, 0, 1, "R7 window 15");

    // R11 / R4: core 1 watchdog one-shot, count 2, prescale 0
    req(1, wa(5, 8), 2'd2, 2'd0, 32'd1, 0, 0, "R11 wdog enable");
    repeat (8) @(negedge clk);
    chk(irq == 4'b1000, "R4 R11 wdog irq position", 32'(irq), 32'h8);
    req(0, wa(5, 12), 2'd2, 2'd0, 0, 32'd1, 0, "R11 wdog status");
    req(0, wa(5, 4), 2'd2, 2'd0, 0, 32'd0, 0, "R11 one-shot count zero");
    req(1, wa(5, 12), 2'd2, 2'd0, 32'd1, 0, 0, "R10 status clear");
    chk(irq == '0, "R10 irq cleared", 32'(irq), 32'd0);

    // R11: core 0 timer auto-reload, reload 5, prescale 4 -> 25 cycles
    req(1, wa(0, 8), 2'd2, 2'd0, 32'h0000_0403, 0, 0, "R11 timer enable");
    begin
      int k = 0;
      while (!irq[0] && k < 100) begin @(negedge clk); k++; end
      chk(irq[0] && k >= 15, "R11 R4 first expiry", 32'(k), 32'd24);
    end
    chk(irq[3:1] == 3'b000, "R4 only timer0 irq", 32'(irq), 32'h1);
    req(1, wa(2, 12), 2'd2, 2'd0, 32'd1, 0, 0, "R11 clear");
    chk(irq[0] == 1'b0, "R11 irq dropped", 32'(irq), 32'd0);
    begin
      int k = 0;
      while (!irq[0] && k < 100) begin @(negedge clk); k++; end
      chk(irq[0] && k >= 15, "R11 auto-reload second expiry", 32'(k), 32'd24);
    end
    req(1, wa(2, 8), 2'd2, 2'd0, 32'd0, 0, 0, "R11 disable");
    req(1, wa(0, 12), 2'd2, 2'd0, 32'd1, 0, 0, "R11 final clear");
    repeat (3) @(negedge clk);
    chk(irq == '0, "R11 idle after disable", 32'(irq), 32'd0);

    repeat (4) @(negedge clk);
    chk(sb_q.size() == 0, "R8 missing responses", 32'(sb_q.size()), 32'd0);
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule